// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block is a synchronous serial port for a small 4-bit controller core. Software loads a data byte, selects whether the shift clock is generated on chip or supplied from outside, picks a 4-bit or 8-bit transfer, and sets a start bit. The port then sends the selected field most significant bit first on its serial output and takes in the same number of bits from its serial input. When the last bit has been received, it raises a completion flag.

With the on-chip clock, the shift clock is made by counting pulses of the instruction-cycle strobe. Each half period lasts a fixed number of strobes. With the outside clock, the incoming clock pin is synchronised and its edges drive the shifting. Output data moves on falling clock edges and input data is taken on rising edges. The shift clock rests high between transfers. The completion flag can always be read by polling. It reaches the interrupt request output only when software routes it there. After reset, the request line belongs to the external interrupt pin.

Top module: `sio_shift_port`

## Requirements
- R1: After reset the control register reads 0x00, `sck_oe` is 0, `sck_out` is 1 and `irq` is 0.
- R2: A control write (select 1) with bit0 (enable) and bit3 (start) both 1 while idle sets the busy bit (bit5) in the cycle after the write. A start write with bit0 at 0 leaves busy at 0. Bit3 always reads 0.
- R3: `sck_oe` equals enable AND bit1 (internal clock). With the internal clock, `sck_out` stays low for 32 `cyc_en` pulses after a start and then toggles every 32 pulses. Clock cycles with `cyc_en` low do not count.
- R4: `sck_out` is high whenever no transfer is busy, and this includes the cycle in which a transfer completes.
- R5: `so` presents the top bit of the field as soon as a transfer starts, then moves one bit lower at each falling shift-clock edge. It never changes while the internal shift clock is high.
- R6: At each rising shift-clock edge the port shifts `si` into bit0 of the field. After the transfer, the data register (select 0) holds the received bits.
- R7: Control bit2 = 1 selects an 8-bit transfer over bits 7..0. Bit2 = 0 selects a 4-bit transfer over bits 3..0, and bits 7..4 of the data register are left unchanged.
- R8: At the rising edge that carries the last bit, busy clears and the completion flag (control bit4) sets.
- R9: Writing 1 to control bit4 while idle clears the completion flag. A start also clears it.
- R10: While busy, every write to either register is ignored. The data and control contents stay as they were.
- R11: With bit1 = 0, `sck_oe` is 0 and shifting follows `sck_in` after a two-flop synchroniser, using the same edge rules. Edges on `sck_in` while idle change nothing.
- R12: `irq` equals the completion flag AND control bit6 (routing). Routing is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 data, 1 control |
| wr_data | input | 8 | Write value |
| rd_sel | input | 1 | Read target: 0 data, 1 control |
| rd_data | output | 8 | Read value of the selected register |
| cyc_en | input | 1 | Instruction-cycle enable strobe |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| sck_in | input | 1 | Shift clock from the pin (outside clock mode) |
| sck_out | output | 1 | Generated shift clock |
| sck_oe | output | 1 | Drive enable for the shift clock pin |
| irq | output | 1 | Routed completion interrupt request |

## Verification
The internal-clock transfer runs with a strobe on every cycle and again with a strobe on every other cycle. This separates counting strobes from counting clocks. Both transfer lengths are run with data patterns whose upper and lower nibbles differ, so a wrong field, a wrong bit order or a disturbed upper nibble each give a different result. Writes made during a transfer try to change both the length and the enable. Clock edges are applied on the external pin while idle, to show that only a started transfer responds to them. Routing the flag, clearing it, and restarting over a set flag show the polled and routed views of completion apart.

// File: rtl/sio_pkg.sv
package sio_pkg;
   // control register bit positions
   localparam int CB_EN     = 0;
   localparam int CB_INTCLK = 1;
   localparam int CB_LEN8   = 2;
   localparam int CB_GO     = 3;
   localparam int CB_FLAG   = 4;
   localparam int CB_BUSY   = 5;
   localparam int CB_ROUTE  = 6;
   localparam int CTRL_BITS = 7;

   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_CTRL = 1'b1
   } sio_sel_e;

   typedef struct packed {
      logic route;
      logic len8;
      logic intclk;
      logic en;
   } sio_cfg_t;
endpackage

// File: rtl/sio_sck_sync.sv
module sio_sck_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int LEN = STAGES + 1;

   logic [LEN-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[LEN-2:0], pin};
   end

   assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
   parameter int HALF_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic cyc_en,
   output logic sck,
   output logic rise,
   output logic fall
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          sck_q;
   logic          wrap;

   assign wrap = run & cyc_en & (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (start) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (cyc_en) begin
         if (wrap) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sck  = sck_q;
   assign rise = wrap & ~sck_q;
   assign fall = wrap &  sck_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              start,
   input  logic              len8,
   input  logic              si,
   input  logic              rise,
   input  logic              fall,
   output logic [DATA_W-1:0] data,
   output logic              so,
   output logic              last
);
   localparam int CW = $clog2(DATA_W);

   logic [DATA_W-1:0] sr_q;
   logic [DATA_W-1:0] shl;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     top_idx;
   logic              so_q;

   assign top_idx = len8 ? CW'(DATA_W - 1) : CW'(SHORT_W - 1);

   // bit 0 takes the serial input; bits beyond the short field hold in short mode
   for (genvar b = 0; b < DATA_W; b++) begin : g_shl
      if (b == 0) begin : g_lsb
         assign shl[b] = si;
      end else if (b < SHORT_W) begin : g_short
         assign shl[b] = sr_q[b-1];
      end else begin : g_long
         assign shl[b] = len8 ? sr_q[b-1] : sr_q[b];
      end
   end

   assign last = rise & (cnt_q == top_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
         so_q  <= 1'b1;
      end else begin
         if (load) sr_q <= load_val;
         if (start) begin
            cnt_q <= '0;
            so_q  <= sr_q[top_idx];
         end
         if (rise) begin
            sr_q  <= shl;
            cnt_q <= cnt_q + 1'b1;
         end
         if (fall) so_q <= sr_q[top_idx];
      end
   end

   assign data = sr_q;
   assign so   = so_q;
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SHORT_W     = 4,
   parameter int HALF_CYC    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cyc_en,
   input  logic              si,
   output logic              so,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              irq
);
   if (DATA_W < CTRL_BITS) begin : g_chk_w
      $error("DATA_W must hold the control bits");
   end
   if (SHORT_W < 1 || SHORT_W >= DATA_W) begin : g_chk_s
      $error("SHORT_W must lie between 1 and DATA_W-1");
   end
   if (HALF_CYC < 2) begin : g_chk_h
      $error("HALF_CYC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_y
      $error("SYNC_STAGES must be at least 2");
   end

   sio_cfg_t cfg_q;
   logic     busy_q;
   logic     flag_q;
   logic     wr_ok, ctrl_wr, data_wr, go, go_int;
   logic     rise_i, fall_i, rise_x, fall_x;
   logic     rise, fall, last;
   logic     len8_sel;
   logic [DATA_W-1:0] sr_data;

   assign wr_ok   = wr_en & ~busy_q;
   assign ctrl_wr = wr_ok & (sio_sel_e'(wr_sel) == SEL_CTRL);
   assign data_wr = wr_ok & (sio_sel_e'(wr_sel) == SEL_DATA);
   assign go      = ctrl_wr & wr_data[CB_GO] & wr_data[CB_EN];
   assign go_int  = go & wr_data[CB_INTCLK];

   sio_sck_gen #(.HALF_CYC(HALF_CYC)) u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (go_int),
      .run    (busy_q & cfg_q.intclk),
      .cyc_en (cyc_en),
      .sck    (sck_out),
      .rise   (rise_i),
      .fall   (fall_i)
   );

   sio_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sck_in),
      .rise  (rise_x),
      .fall  (fall_x)
   );

   assign rise     = busy_q & (cfg_q.intclk ? rise_i : rise_x);
   assign fall     = busy_q & (cfg_q.intclk ? fall_i : fall_x);
   assign len8_sel = go ? wr_data[CB_LEN8] : cfg_q.len8;

   sio_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (data_wr),
      .load_val (wr_data),
      .start    (go),
      .len8     (len8_sel),
      .si       (si),
      .rise     (rise),
      .fall     (fall),
      .data     (sr_data),
      .so       (so),
      .last     (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         busy_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            cfg_q.en     <= wr_data[CB_EN];
            cfg_q.intclk <= wr_data[CB_INTCLK];
            cfg_q.len8   <= wr_data[CB_LEN8];
            cfg_q.route  <= wr_data[CB_ROUTE];
         end
         if (go)        busy_q <= 1'b1;
         else if (last) busy_q <= 1'b0;
         if (go)                              flag_q <= 1'b0;
         else if (last)                       flag_q <= 1'b1;
         else if (ctrl_wr && wr_data[CB_FLAG]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      if (sio_sel_e'(rd_sel) == SEL_DATA) begin
         rd_data = sr_data;
      end else begin
         rd_data           = '0;
         rd_data[CB_EN]    = cfg_q.en;
         rd_data[CB_INTCLK]= cfg_q.intclk;
         rd_data[CB_LEN8]  = cfg_q.len8;
         rd_data[CB_FLAG]  = flag_q;
         rd_data[CB_BUSY]  = busy_q;
         rd_data[CB_ROUTE] = cfg_q.route;
      end
   end

   assign sck_oe = cfg_q.en & cfg_q.intclk;
   assign irq    = flag_q & cfg_q.route;
endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       flag,
   input logic       sck,
   input logic       sck_oe,
   input logic       so,
   input logic [3:0] cfg
);
   AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck);  // R4

   AST_SO_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && busy && $past(busy) && sck && $past(sck)) |-> $stable(so));  // R5

   AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> flag);  // R8

   AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !flag);  // R9

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(cfg));  // R10
endmodule

bind sio_shift_port sio_shift_port_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy_q),
   .flag   (flag_q),
   .sck    (sck_out),
   .sck_oe (sck_oe),
   .so     (so),
   .cfg    (cfg_q)
);

// File: tb/sio_shift_port_test.sv
module sio_shift_port_test;
   localparam logic [7:0] C_EN = 8'h01, C_INT = 8'h02, C_LEN8 = 8'h04,
                          C_GO = 8'h08, C_FLAG = 8'h10, C_BUSY = 8'h20,
                          C_ROUTE = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       cyc_en = 1'b1;
   logic       si = 1'b0;
   logic       so;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, irq;

   int checks = 0;
   int errors = 0;
   int div = 1;
   int tick = 0;
   bit timed_out = 1'b0;

   sio_shift_port uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .cyc_en(cyc_en), .si(si), .so(so),
      .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .irq(irq)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tick++;
      cyc_en = (div <= 1) ? 1'b1 : ((tick % div) == 0);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b1, v);
      chk("R1 ctrl after reset", v, 8'h00);
      chk("R1 sck_oe after reset", sck_oe, 1'b0);
      chk("R1 sck_out after reset", sck_out, 1'b1);
      chk("R1 irq after reset", irq, 1'b0);
   endtask

   task automatic t_disabled_go();
      logic [7:0] v;
      wr(1'b1, C_INT | C_GO);
      rd(1'b1, v);
      chk("R2 start without enable stays idle", v, C_INT);
      chk("R3 no clock drive while disabled", sck_oe, 1'b0);
      repeat (40) @(negedge clk);
      chk("R4 clock stays high when not started", sck_out, 1'b1);
   endtask

   task automatic run_int(input bit len8, input logic [7:0] tx, input logic [7:0] rx,
                          input int d, input bit poke, input logic [7:0] extra);
      int n, top, ph, bits, mn, mx, firstlen, guard;
      bit first, prev;
      logic [7:0] v, cap, expd;
      n = len8 ? 8 : 4;
      top = n - 1;
      div = d;
      wr(1'b0, tx);
      si = rx[top];
      wr(1'b1, C_EN | C_INT | (len8 ? C_LEN8 : 8'h00) | C_GO | extra);
      rd(1'b1, v);
      chk("R2 busy after start", v & (C_BUSY | C_GO), C_BUSY);
      chk("R9 start clears flag", v & C_FLAG, 8'h00);
      chk("R3 clock drive with internal clock", sck_oe, 1'b1);
      if (poke) begin
         fork
            begin
               wr(1'b0, 8'h5A);
               wr(1'b1, 8'h00);
            end
         join_none
      end
      prev = sck_out; ph = 1; bits = 0; mn = 1000000; mx = 0;
      first = 1'b1; firstlen = 0; cap = '0; guard = 0;
      while (bits < n && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (sck_out == prev) begin
            ph++;
         end else begin
            if (first) firstlen = ph;
            else begin
               if (ph < mn) mn = ph;
               if (ph > mx) mx = ph;
            end
            first = 1'b0;
            ph = 1;
            prev = sck_out;
            if (sck_out) begin
               cap = {cap[6:0], so};
               bits++;
            end else begin
               si = rx[top - bits];
            end
         end
      end
      rd(1'b1, v);
      chk("R8 busy clear and flag set at last bit", v & (C_BUSY | C_FLAG), C_FLAG);
      chk("R4 clock high after transfer", sck_out, 1'b1);
      chk("R5 bits sent msb first", cap & ((8'h1 << n) - 1), tx & ((8'h1 << n) - 1));
      if (n > 1) begin
         chk("R3 half period length min", mn, 32 * d);
         chk("R3 half period length max", mx, 32 * d);
      end
      if (d == 1) chk("R3 first low phase", firstlen, 32);
      expd = len8 ? rx : {tx[7:4], rx[3:0]};
      rd(1'b0, v);
      chk(len8 ? "R6 received byte" : "R7 short field keeps upper nibble", v, expd);
      chk("R12 irq follows flag and routing", irq, (extra & C_ROUTE) != 0);
      if (poke) begin
         rd(1'b1, v);
         chk("R10 control unchanged by busy write", v, C_EN | C_INT | C_LEN8 | C_FLAG);
      end
      div = 1;
   endtask

   task automatic t_route();
      logic [7:0] v;
      chk("R12 irq low while routing off", irq, 1'b0);
      wr(1'b1, C_EN | C_ROUTE);
      chk("R12 irq high once routed", irq, 1'b1);
      rd(1'b1, v);
      chk("R12 flag kept by plain control write", v, C_EN | C_ROUTE | C_FLAG);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(1'b1, C_EN | C_ROUTE | C_FLAG);
      rd(1'b1, v);
      chk("R9 write one clears flag", v, C_EN | C_ROUTE);
      chk("R9 irq drops after clear", irq, 1'b0);
   endtask

   task automatic t_ext_idle();
      logic [7:0] v;
      wr(1'b1, C_EN | C_FLAG);
      wr(1'b0, 8'h66);
      for (int i = 0; i < 3; i++) begin
         sck_in = 1'b0; si = i[0];
         repeat (4) @(negedge clk);
         sck_in = 1'b1;
         repeat (4) @(negedge clk);
      end
      rd(1'b0, v);
      chk("R11 idle pin edges leave data", v, 8'h66);
      rd(1'b1, v);
      chk("R11 idle pin edges leave control", v, C_EN);
   endtask

   task automatic run_ext(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
      int n, top;
      logic [7:0] v, cap, expd;
      n = len8 ? 8 : 4;
      top = n - 1;
      cap = '0;
      wr(1'b0, tx);
      wr(1'b1, C_EN | (len8 ? C_LEN8 : 8'h00) | C_GO);
      chk("R11 no clock drive in outside mode", sck_oe, 1'b0);
      for (int i = 0; i < n; i++) begin
         sck_in = 1'b0;
         repeat (4) @(negedge clk);
         cap = {cap[6:0], so};
         si = rx[top - i];
         sck_in = 1'b1;
         repeat (4) @(negedge clk);
      end
      rd(1'b1, v);
      chk("R11 outside clock transfer completes", v & (C_BUSY | C_FLAG), C_FLAG);
      chk("R11 outside clock sends msb first", cap & ((8'h1 << n) - 1), tx & ((8'h1 << n) - 1));
      expd = len8 ? rx : {tx[7:4], rx[3:0]};
      rd(1'b0, v);
      chk("R11 outside clock received data", v, expd);
   endtask

   initial begin
      fork
         begin
            repeat (5) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_disabled_go();
            run_int(1'b1, 8'hA5, 8'h3C, 1, 1'b0, 8'h00);
            t_route();
            run_int(1'b0, 8'hB6, 8'h09, 1, 1'b0, C_ROUTE);
            t_clear();
            run_int(1'b1, 8'h81, 8'hE7, 2, 1'b1, 8'h00);
            t_ext_idle();
            run_ext(1'b1, 8'h4D, 8'hB2);
            run_ext(1'b0, 8'h3C, 8'h05);
         end
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=expired expected=finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule